// File: doc/BRIEF.md
# Byte-Lane Write, Selectable-Latency Synchronous Memory Datapath

This block is the storage and data path of a synchronous memory whose word is split into four byte lanes of 8 or 9 bits each. A burst sequencer ahead of it supplies, on every rising clock edge, a cycle-valid flag, the current burst address, and a flag saying whether the access began with a processor-style start. The block decodes the global write enable, the byte-write enable and the per-lane enables into lane write strobes, updates the selected lanes of the array, and returns read data through one register (flow-through) or two registers (pipelined).

The data output comes with a drive flag that stands for the tristate enable of the data pins. It is high only when the asynchronous output enable is high, a read result is in the output stage, and the block is awake. Any sampled write turns it off, whatever the output enable does. While the sleep input is high, the array keeps its contents and accepts no accesses.

Top module: `bwsram_datapath`

## Requirements
- R1: When `gwe_n` is 0 on a valid cycle that is not a processor start, all four lanes at `addr` take `wdata`, whatever `bw_n` holds.
- R2: When `gwe_n` is 1 and `bwe_n` is 0, lane i (bits i*LANE_W and up) is written only if `bw_n[i]` is 0, and the other lanes keep their old contents. If all of `bw_n` is 1, the cycle is a read.
- R3: When `gwe_n` and `bwe_n` are both 1, the cycle is a read and nothing is written.
- R4: On an edge with `cyc_proc_start` at 1, the write enables are ignored and the cycle is a read of `addr`.
- R5: On an edge with `cyc_proc_start` at 0, a write enable takes effect on that same edge, including the first edge of a burst.
- R6: With `flow_thru` at 1, the data of the address read at edge k is on `rdata`, with `rdata_drive` at 1, right after edge k.
- R7: With `flow_thru` at 0, the data of the address read at edge k appears right after edge k+1.
- R8: In the cycle after any edge that writes a lane, `rdata_drive` is 0, even when `oe` is 1.
- R9: `oe` acts without a clock: when it is 0, `rdata_drive` is 0 at once, and it comes back as soon as `oe` returns to 1.
- R10: While `sleep` is 1, `rdata_drive` is 0 and writes are blocked. The stored contents are intact after waking.
- R11: Reading the same address on consecutive edges (a suspended burst) returns the same word each cycle. A new address each edge (a continued burst) returns each word in turn.
- R12: After a deselect (`cyc_valid` at 0), `rdata_drive` falls once the read stages have drained: one edge in flow-through mode, two edges in pipelined mode.
- R13: After a synchronous reset, `rdata_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_thru | input | 1 | 1: one-register read path, 0: two-register read path |
| sleep | input | 1 | Low-power hold, contents retained |
| oe | input | 1 | Asynchronous output enable, active high |
| cyc_valid | input | 1 | Selected access on this edge |
| cyc_proc_start | input | 1 | This edge starts a processor-style cycle |
| addr | input | ADDR_W | Burst address from the sequencer |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data |
| rdata_drive | output | 1 | Data pins driven when 1 |

## Verification
The hardest case to reach is an edge that is both a processor-style start and carries an active write enable. The enables must be ignored there and honoured on the next edge at the same address. The stimulus places this pair directly after a known fill. It checks that the start edge returns the old word with the driver on, that the following single-lane write turns the driver off, and that a read-back shows only that lane changed. The bench also sweeps all sixteen lane masks over one address and streams the whole array in both latency modes, so that each word can be checked against its arithmetic pattern.

// File: rtl/bwsram_pkg.sv
// Shared definitions for the byte-lane memory datapath.
// Assumes: lanes are numbered from bit 0 upward.
package bwsram_pkg;
    typedef enum logic {
        LAT_PIPE = 1'b0,
        LAT_FLOW = 1'b1
    } rd_lat_e;
endpackage

// File: rtl/bwsram_wdec.sv
// Write-enable decode: turns the global, byte and per-lane enables into lane
// strobes, and marks read cycles. Assumes the enables are held for the whole cycle.
module bwsram_wdec #(
    parameter int LANES = 4
) (
    input  logic             cyc_valid,
    input  logic             sleep,
    input  logic             proc_start,
    input  logic             gwe_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we,
    output logic             rd_now
);
    logic active;
    logic sample_we;

    // An access counts only when selected and awake. A processor start masks the enables.
    always_comb begin
        active    = cyc_valid && !sleep;
        sample_we = active && !proc_start;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Per-lane strobe: the global enable wins, otherwise the byte enable gates the lane bit.
        always_comb lane_we[i] = sample_we && (!gwe_n || (!bwe_n && !bw_n[i]));
    end

    // A cycle is a read when it is active and no lane is written.
    always_comb rd_now = active && (lane_we == '0);
endmodule

// File: rtl/bwsram_array.sv
// Storage array split into independent lanes, each with its own write strobe.
// Assumes a write and a combinational read at the same address; the read is only used on non-write edges.
module bwsram_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rword
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Update this lane's word when its strobe is set.
        always_ff @(posedge clk) begin
            if (lane_we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
        end

        // Present this lane's stored word for the read stages.
        always_comb rword[i*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/bwsram_rdpipe.sv
// Read stages and output drive control. Stage one captures the array word on a
// read edge, and stage two delays it one more edge. The mode selects which stage is
// shown. Assumes the mode changes only while idle.
module bwsram_rdpipe #(
    parameter int W = 36
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  bwsram_pkg::rd_lat_e    lat_mode,
    input  logic                   sleep,
    input  logic                   oe,
    input  logic                   rd_now,
    input  logic                   wr_now,
    input  logic [W-1:0]           rword,
    output logic [W-1:0]           rdata,
    output logic                   rdata_drive
);
    import bwsram_pkg::*;

    logic [W-1:0] s1_data, s2_data;
    logic         s1_v, s2_v, wr_q;
    logic         sel_v;

    // First stage: capture the read word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_data <= '0;
            s1_v    <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            if (rd_now) s1_data <= rword;
            s1_v <= rd_now;
            wr_q <= wr_now;
        end
    end

    // Second stage: one further edge of delay for pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_data <= '0;
            s2_v    <= 1'b0;
        end else begin
            s2_data <= s1_data;
            s2_v    <= s1_v;
        end
    end

    // Output select and drive: a write, sleep or a low output enable turns the driver off.
    always_comb begin
        rdata       = (lat_mode == LAT_FLOW) ? s1_data : s2_data;
        sel_v       = (lat_mode == LAT_FLOW) ? s1_v : s2_v;
        rdata_drive = oe && sel_v && !wr_q && !sleep;
    end

    assert_drive_needs_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drive |-> oe);
    assert_stage_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |=> s2_v);
endmodule

// File: rtl/bwsram_datapath.sv
// Top of the byte-lane memory datapath: write decode, lane array and read stages.
// Assumes the burst sequencer supplies the address and start type on every edge.
module bwsram_datapath #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru,
    input  logic              sleep,
    input  logic              oe,
    input  logic              cyc_valid,
    input  logic              cyc_proc_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gwe_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              rdata_drive
);
    import bwsram_pkg::*;

    logic [LANES-1:0] lane_we;
    logic             rd_now;
    logic             wr_now;
    logic [W-1:0]     rword;
    rd_lat_e          lat_mode;

    // Map the static mode pin and reduce the lane strobes to a write flag.
    always_comb begin
        lat_mode = flow_thru ? LAT_FLOW : LAT_PIPE;
        wr_now   = |lane_we;
    end

    bwsram_wdec #(.LANES(LANES)) u_wdec (
        .cyc_valid (cyc_valid),
        .sleep     (sleep),
        .proc_start(cyc_proc_start),
        .gwe_n     (gwe_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .lane_we   (lane_we),
        .rd_now    (rd_now)
    );

    bwsram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .lane_we(lane_we),
        .addr   (addr),
        .wdata  (wdata),
        .rword  (rword)
    );

    bwsram_rdpipe #(.W(W)) u_rdpipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .lat_mode   (lat_mode),
        .sleep      (sleep),
        .oe         (oe),
        .rd_now     (rd_now),
        .wr_now     (wr_now),
        .rword      (rword),
        .rdata      (rdata),
        .rdata_drive(rdata_drive)
    );

    assert_proc_start_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_proc_start) |-> (lane_we == '0));
    assert_sleep_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!rdata_drive && lane_we == '0));
    assert_write_offs_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |=> !rdata_drive);
    assert_idle_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && gwe_n && bwe_n) |-> (lane_we == '0));
endmodule

// File: tb/bwsram_datapath_bench.sv
// Self-checking bench: fills the array, sweeps lane masks, streams reads in both modes.
module bwsram_datapath_bench;
    localparam int LANES = 4;
    localparam int LB    = 9;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int W     = LANES * LB;

    logic clk = 1'b0;
    logic rst_n, flow_thru, sleep, oe, cyc_valid, cyc_proc_start, gwe_n, bwe_n;
    logic [AW-1:0]    addr;
    logic [LANES-1:0] bw_n;
    logic [W-1:0]     wdata, rdata;
    logic             rdata_drive;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] ref_mem [DEPTH];

    always #5 clk = ~clk;

    bwsram_datapath u_bwsram_datapath (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .sleep(sleep), .oe(oe),
        .cyc_valid(cyc_valid), .cyc_proc_start(cyc_proc_start), .addr(addr),
        .gwe_n(gwe_n), .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    function automatic logic [W-1:0] pat(input int a, input int s);
        logic [W-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*LB +: LB] = LB'(a * 7 + i * 37 + s * 13);
        return r;
    endfunction

    // Apply one cycle's inputs, wait for the edge, and return a little after it.
    task automatic step(input logic v, input logic p, input int a, input logic g,
                        input logic be, input logic [LANES-1:0] bw, input logic [W-1:0] d);
        cyc_valid = v; cyc_proc_start = p; addr = AW'(a);
        gwe_n = g; bwe_n = be; bw_n = bw; wdata = d;
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input int a);
        step(1'b1, 1'b0, a, 1'b1, 1'b1, '1, '0);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 0, 1'b1, 1'b1, '1, '0);
    endtask

    task automatic chk_rd(input string req, input logic [W-1:0] exp);
        checks++;
        if (rdata_drive !== 1'b1 || rdata !== exp) begin
            fails++;
            $display("FAIL %s: drive=%b data=%h expected drive=1 data=%h", req, rdata_drive, rdata, exp);
        end
    endtask

    task automatic chk_off(input string req);
        checks++;
        if (rdata_drive !== 1'b0) begin
            fails++;
            $display("FAIL %s: drive=%b expected 0", req, rdata_drive);
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] d;
        rst_n = 1'b0; flow_thru = 1'b1; sleep = 1'b0; oe = 1'b1;
        idle(); idle();
        chk_off("R13 reset");
        rst_n = 1'b1;

        // R1/R5: fill every address with a global write on controller-start edges.
        for (int a = 0; a < DEPTH; a++) begin
            ref_mem[a] = pat(a, 1);
            step(1'b1, 1'b0, a, 1'b0, 1'b1, 4'b0101, ref_mem[a]);
            chk_off("R8 write offs drive");
        end
        // R6/R11: flow-through continued burst over the whole array.
        for (int a = 0; a < DEPTH; a++) begin
            rd(a);
            chk_rd("R1 R6 flow read", ref_mem[a]);
        end
        idle();
        chk_off("R12 flow deselect");

        // R2: every lane mask at address 3, with a read-back after each.
        for (int m = 0; m < 16; m++) begin
            d = pat(m, 5);
            step(1'b1, 1'b0, 3, 1'b1, 1'b0, 4'(m), d);
            for (int i = 0; i < LANES; i++)
                if (!m[i]) ref_mem[3][i*LB +: LB] = d[i*LB +: LB];
            if (m == 15) chk_rd("R2 all lanes off is read", ref_mem[3]);
            else         chk_off("R8 byte write offs drive");
            rd(3);
            chk_rd("R2 lane mask", ref_mem[3]);
        end

        // R3: both enables high with lane bits low is a read.
        step(1'b1, 1'b0, 4, 1'b1, 1'b1, 4'b0000, pat(99, 9));
        chk_rd("R3 no write", ref_mem[4]);

        // R4: processor start ignores the global write, the next edge honours a lane write.
        step(1'b1, 1'b1, 5, 1'b0, 1'b1, '1, pat(77, 3));
        chk_rd("R4 start edge reads", ref_mem[5]);
        d = pat(55, 2);
        step(1'b1, 1'b0, 5, 1'b1, 1'b0, 4'b1110, d);
        ref_mem[5][0 +: LB] = d[0 +: LB];
        chk_off("R8 write after start");
        rd(5);
        chk_rd("R4 later edge wrote lane0", ref_mem[5]);

        // R9: output enable acts without a clock.
        oe = 1'b0; #1;
        chk_off("R9 oe low");
        oe = 1'b1; #1;
        chk_rd("R9 oe high again", ref_mem[5]);

        // R11: suspended burst keeps the same word.
        rd(6); rd(6);
        chk_rd("R11 suspend", ref_mem[6]);

        // R10: sleep turns off drive and blocks writes.
        sleep = 1'b1; #1;
        chk_off("R10 sleep drive");
        step(1'b1, 1'b0, 7, 1'b0, 1'b1, '1, pat(11, 11));
        chk_off("R10 sleep write cycle");
        sleep = 1'b0;
        rd(7);
        chk_rd("R10 contents kept", ref_mem[7]);

        // R7/R12: pipelined mode streams with one extra edge of delay.
        idle(); idle();
        flow_thru = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            rd(a);
            if (a > 0) chk_rd("R7 pipe read", ref_mem[a-1]);
        end
        idle();
        chk_rd("R12 pipe drains last word", ref_mem[DEPTH-1]);
        idle();
        chk_off("R12 pipe deselect");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule